// File: doc/BRIEF.md
# FAT16 Volume Geometry Extractor

This block watches the first sector of an SD card volume as it streams past, one byte per strobe, each byte tagged with its position inside the 512-byte sector. It keeps only the handful of boot-record bytes it needs, and assembles the multi-byte fields little-endian as their bytes arrive. No copy of the sector is stored.

Once the last byte of the sector has been taken, the block works out the volume layout. This covers the sector where the root directory begins, how many sectors the root directory spans, and the sector where the data area begins. The raw parameters and the derived values appear together on registered outputs. A done flag marks the result valid. An error flag marks a boot record that cannot be mounted.

A filesystem walker uses it as follows. It pulses start, streams sector 0, waits for done, and then reads the geometry.

Top module: `boot_geometry_extract`

## Requirements
- R1: After reset, done and error are low and every geometry output reads zero.
- R2: A start pulse clears done, error and every geometry output in the next cycle, and begins a new capture.
- R3: Done is low in the cycle right after the strobe carrying index 511 is taken. It is high from the cycle after that, and stays high until the next start.
- R4: When done is high, the outputs carry these fields, little-endian: sectors per cluster from byte 13, reserved sectors from bytes 14 (low) and 15 (high), FAT copies from byte 16, root entries from bytes 17 (low) and 18 (high), media code from byte 21, and sectors per FAT from bytes 22 (low) and 23 (high).
- R5: The root start output equals reserved sectors plus FAT copies times sectors per FAT.
- R6: The root span output equals the number of 512-byte sectors needed to hold the root entries at 32 bytes each, rounded up.
- R7: The data start output equals the root start plus the root span.
- R8: The error flag is set with done when byte 0 is not 0xEB or byte 2 is not 0x90.
- R9: The error flag is set with done when bytes 11 (low) and 12 (high) do not form 0x0200.
- R10: The error flag is set with done when sectors per cluster is zero or not a power of two, or when the FAT copy count is zero.
- R11: Strobes that arrive before the first start, or after done and before the next start, change no output.
- R12: Fields are placed by byte index, so a sector streamed in any order with index 511 last gives the same result as one streamed in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that clears the results and begins a capture |
| byte_valid | input | 1 | Byte strobe |
| byte_idx | input | 9 | Position of the byte within the sector |
| byte_data | input | 8 | Byte value |
| geo_done | output | 1 | Geometry valid |
| geo_err | output | 1 | Boot record not mountable |
| clus_sectors | output | 8 | Sectors per cluster |
| rsvd_sectors | output | 16 | Reserved sector count |
| fat_count | output | 8 | Number of FAT copies |
| dir_entries | output | 16 | Root directory entry count |
| fat_sectors | output | 16 | Sectors per FAT |
| media_code | output | 8 | Media descriptor byte |
| root_start | output | 32 | First sector of the root directory |
| root_span | output | 16 | Root directory length in sectors |
| data_start | output | 32 | First sector of the data area |

## Verification
The bench builds the block with its default parameters: a 512-byte sector and 32-bit sector addresses. At that address width the largest possible root start, 65535 + 255 × 65535, cannot overflow. The bench can therefore push the reserved count, the FAT size and the FAT copy count to their limits, and compare the full-width sums against its own arithmetic. The 16-bit entry field reaches a root span of 4096 sectors, and an entry count of one reaches a single partial sector. Streams are sent in order with random idle gaps, and also in reverse order.

// File: rtl/bootrec_pkg.sv
package bootrec_pkg;

  // Boot-record bytes that are retained, by slot number
  localparam int SL_JMP    = 0;
  localparam int SL_NOP    = 1;
  localparam int SL_BPS_LO = 2;
  localparam int SL_BPS_HI = 3;
  localparam int SL_SPC    = 4;
  localparam int SL_RSV_LO = 5;
  localparam int SL_RSV_HI = 6;
  localparam int SL_NFAT   = 7;
  localparam int SL_ENT_LO = 8;
  localparam int SL_ENT_HI = 9;
  localparam int SL_MEDIA  = 10;
  localparam int SL_SPF_LO = 11;
  localparam int SL_SPF_HI = 12;
  localparam int NSLOT     = 13;

  localparam logic [7:0] JMP_OPCODE = 8'hEB;
  localparam logic [7:0] NOP_OPCODE = 8'h90;
  localparam int DIR_ENT_BYTES = 32;

  // Byte position inside the sector for each slot
  function automatic int slot_offset(input int s);
    case (s)
      SL_JMP:    return 0;
      SL_NOP:    return 2;
      SL_BPS_LO: return 11;
      SL_BPS_HI: return 12;
      SL_SPC:    return 13;
      SL_RSV_LO: return 14;
      SL_RSV_HI: return 15;
      SL_NFAT:   return 16;
      SL_ENT_LO: return 17;
      SL_ENT_HI: return 18;
      SL_MEDIA:  return 21;
      SL_SPF_LO: return 22;
      default:   return 23;
    endcase
  endfunction

endpackage

// File: rtl/bootrec_byte_slot.sv
module bootrec_byte_slot #(
  parameter int IDX_W  = 9,
  parameter int OFFSET = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [7:0]       q
);

  logic hit;
  assign hit = take && (idx == IDX_W'(OFFSET));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      q <= 8'h00;
    end else if (hit) begin
      q <= data;
    end
  end

  // R2
  slot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> q == 8'h00);

endmodule

// File: rtl/bootrec_layout_calc.sv
module bootrec_layout_calc
  import bootrec_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int SECT_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  finish,
  input  logic [NSLOT-1:0][7:0] slots,
  output logic                  done,
  output logic                  err,
  output logic [7:0]            spc_q,
  output logic [15:0]           rsv_q,
  output logic [7:0]            nfat_q,
  output logic [15:0]           ent_q,
  output logic [15:0]           spf_q,
  output logic [7:0]            media_q,
  output logic [SECT_W-1:0]     root_start_q,
  output logic [15:0]           root_span_q,
  output logic [SECT_W-1:0]     data_start_q
);

  localparam int ENT_PER_SECT = SECT_BYTES / DIR_ENT_BYTES;
  localparam int ENT_SHIFT    = $clog2(ENT_PER_SECT);

  logic [15:0]       bps_c, rsv_c, ent_c, spf_c;
  logic [7:0]        spc_c, nfat_c;
  logic [23:0]       fat_area_c;
  logic [16:0]       ent_round_c;
  logic [15:0]       span_c;
  logic [SECT_W-1:0] root_c, data_c;
  logic              sig_bad_c, size_bad_c, clus_bad_c, err_c;

  always_comb begin
    bps_c  = {slots[SL_BPS_HI], slots[SL_BPS_LO]};
    rsv_c  = {slots[SL_RSV_HI], slots[SL_RSV_LO]};
    ent_c  = {slots[SL_ENT_HI], slots[SL_ENT_LO]};
    spf_c  = {slots[SL_SPF_HI], slots[SL_SPF_LO]};
    spc_c  = slots[SL_SPC];
    nfat_c = slots[SL_NFAT];

    fat_area_c  = 24'(nfat_c) * 24'(spf_c);
    root_c      = SECT_W'(rsv_c) + SECT_W'(fat_area_c);
    ent_round_c = {1'b0, ent_c} + 17'(ENT_PER_SECT - 1);
    span_c      = 16'(ent_round_c >> ENT_SHIFT);
    data_c      = root_c + SECT_W'(span_c);

    sig_bad_c  = (slots[SL_JMP] != JMP_OPCODE) || (slots[SL_NOP] != NOP_OPCODE);
    size_bad_c = (bps_c != 16'(SECT_BYTES));
    clus_bad_c = (spc_c == 8'h00) || ((spc_c & (spc_c - 8'h01)) != 8'h00) ||
                 (nfat_c == 8'h00);
    err_c      = sig_bad_c || size_bad_c || clus_bad_c;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      done         <= 1'b0;
      err          <= 1'b0;
      spc_q        <= '0;
      rsv_q        <= '0;
      nfat_q       <= '0;
      ent_q        <= '0;
      spf_q        <= '0;
      media_q      <= '0;
      root_start_q <= '0;
      root_span_q  <= '0;
      data_start_q <= '0;
    end else if (finish) begin
      done         <= 1'b1;
      err          <= err_c;
      spc_q        <= spc_c;
      rsv_q        <= rsv_c;
      nfat_q       <= nfat_c;
      ent_q        <= ent_c;
      spf_q        <= spf_c;
      media_q      <= slots[SL_MEDIA];
      root_start_q <= root_c;
      root_span_q  <= span_c;
      data_start_q <= data_c;
    end
  end

  // R3
  finish_done_chk: assert property (@(posedge clk) disable iff (rst)
    finish && !clear |=> done);

  // R5
  root_past_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> root_start_q >= SECT_W'(rsv_q));

  // R7
  data_after_root_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> data_start_q >= root_start_q);

  // R8
  err_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

endmodule

// File: rtl/boot_geometry_extract.sv
module boot_geometry_extract
  import bootrec_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int SECT_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          byte_valid,
  input  logic [$clog2(SECT_BYTES)-1:0] byte_idx,
  input  logic [7:0]                    byte_data,
  output logic                          geo_done,
  output logic                          geo_err,
  output logic [7:0]                    clus_sectors,
  output logic [15:0]                   rsvd_sectors,
  output logic [7:0]                    fat_count,
  output logic [15:0]                   dir_entries,
  output logic [15:0]                   fat_sectors,
  output logic [7:0]                    media_code,
  output logic [SECT_W-1:0]             root_start,
  output logic [15:0]                   root_span,
  output logic [SECT_W-1:0]             data_start
);

  localparam int IDX_W = $clog2(SECT_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECT_BYTES - 1);

  logic                  busy_q;
  logic                  finish_q;
  logic                  take;
  logic                  last_take;
  logic [NSLOT-1:0][7:0] slots;

  assign take      = busy_q && byte_valid && !start;
  assign last_take = take && (byte_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      finish_q <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      finish_q <= 1'b0;
    end else begin
      finish_q <= last_take;
      if (last_take) busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    bootrec_byte_slot #(
      .IDX_W  (IDX_W),
      .OFFSET (slot_offset(g))
    ) i_slot (
      .clk   (clk),
      .rst   (rst),
      .clear (start),
      .take  (take),
      .idx   (byte_idx),
      .data  (byte_data),
      .q     (slots[g])
    );
  end

  bootrec_layout_calc #(
    .SECT_BYTES (SECT_BYTES),
    .SECT_W     (SECT_W)
  ) i_layout (
    .clk          (clk),
    .rst          (rst),
    .clear        (start),
    .finish       (finish_q),
    .slots        (slots),
    .done         (geo_done),
    .err          (geo_err),
    .spc_q        (clus_sectors),
    .rsv_q        (rsvd_sectors),
    .nfat_q       (fat_count),
    .ent_q        (dir_entries),
    .spf_q        (fat_sectors),
    .media_q      (media_code),
    .root_start_q (root_start),
    .root_span_q  (root_span),
    .data_start_q (data_start)
  );

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !geo_done && !geo_err && root_start == '0);

  // R3
  done_late_chk: assert property (@(posedge clk) disable iff (rst)
    last_take |=> !geo_done);

  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    geo_done && !start |=> geo_done && $stable(data_start) && $stable(geo_err));

  // R11
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !start |=> $stable(slots));

endmodule

// File: tb/test_boot_geometry_extract.sv
module test_boot_geometry_extract;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [8:0]  byte_idx = '0;
  logic [7:0]  byte_data = '0;
  logic        geo_done, geo_err;
  logic [7:0]  clus_sectors, fat_count, media_code;
  logic [15:0] rsvd_sectors, dir_entries, fat_sectors, root_span;
  logic [31:0] root_start, data_start;

  int vectors = 0;
  int fails   = 0;
  logic [7:0] sec [512];

  always #5 clk = ~clk;

  boot_geometry_extract i_boot_geometry_extract (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
    .byte_idx(byte_idx), .byte_data(byte_data), .geo_done(geo_done),
    .geo_err(geo_err), .clus_sectors(clus_sectors), .rsvd_sectors(rsvd_sectors),
    .fat_count(fat_count), .dir_entries(dir_entries), .fat_sectors(fat_sectors),
    .media_code(media_code), .root_start(root_start), .root_span(root_span),
    .data_start(data_start)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic longint f16(input int lo);
    return longint'({sec[lo+1], sec[lo]});
  endfunction

  function automatic bit exp_err();
    logic [7:0] spc;
    spc = sec[13];
    return (sec[0] != 8'hEB) || (sec[2] != 8'h90) || (f16(11) != 512) ||
           (spc == 0) || ((spc & (spc - 8'd1)) != 0) || (sec[16] == 0);
  endfunction

  function automatic longint exp_root();
    return f16(14) + longint'(sec[16]) * f16(22);
  endfunction

  function automatic longint exp_span();
    return (f16(17) * 32 + 511) / 512;
  endfunction

  task automatic put16(input int lo, input int v);
    sec[lo]   = 8'(v);
    sec[lo+1] = 8'(v >> 8);
  endtask

  task automatic make_sector(input int spc, input int rsv, input int nfat,
                             input int ent, input int spf, input int media);
    for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
    sec[0] = 8'hEB; sec[2] = 8'h90;
    put16(11, 512);
    sec[13] = 8'(spc);
    put16(14, rsv);
    sec[16] = 8'(nfat);
    put16(17, ent);
    sec[21] = 8'(media);
    put16(22, spf);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "done after start", longint'(geo_done), 0);
    chk("R2", "err after start", longint'(geo_err), 0);
    chk("R2", "root_start after start", longint'(root_start), 0);
  endtask

  task automatic send_byte(input int i, input bit gaps);
    if (gaps && ($urandom % 4 == 0)) begin
      @(negedge clk); byte_valid = 1'b0;
    end
    @(negedge clk);
    byte_valid = 1'b1; byte_idx = 9'(i); byte_data = sec[i];
  endtask

  task automatic run(input string tag, input bit reverse, input bit gaps);
    pulse_start();
    for (int k = 0; k < 512; k++) begin
      int i;
      i = reverse ? ((k == 511) ? 511 : 510 - k) : k;
      send_byte(i, gaps);
    end
    @(negedge clk); byte_valid = 1'b0;
    chk("R3", "done one cycle after last byte", longint'(geo_done), 0);
    @(negedge clk);
    chk("R3", "done two cycles after last byte", longint'(geo_done), 1);
    chk(tag, "error flag", longint'(geo_err), longint'(exp_err()));
    chk("R4", "clus_sectors", longint'(clus_sectors), longint'(sec[13]));
    chk("R4", "rsvd_sectors", longint'(rsvd_sectors), f16(14));
    chk("R4", "fat_count", longint'(fat_count), longint'(sec[16]));
    chk("R4", "dir_entries", longint'(dir_entries), f16(17));
    chk("R4", "fat_sectors", longint'(fat_sectors), f16(22));
    chk("R4", "media_code", longint'(media_code), longint'(sec[21]));
    chk("R5", "root_start", longint'(root_start), exp_root());
    chk("R6", "root_span", longint'(root_span), exp_span());
    chk("R7", "data_start", longint'(data_start), exp_root() + exp_span());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", longint'(geo_done), 0);
    chk("R1", "err", longint'(geo_err), 0);
    chk("R1", "data_start", longint'(data_start), 0);
    chk("R1", "dir_entries", longint'(dir_entries), 0);

    // R11 strobes before any start are ignored
    make_sector(4, 1, 2, 512, 200, 8'hF8);
    for (int i = 0; i < 512; i++) send_byte(i, 1'b0);
    @(negedge clk); byte_valid = 1'b0;
    @(negedge clk);
    chk("R11", "done before start", longint'(geo_done), 0);
    chk("R11", "root_start before start", longint'(root_start), 0);

    // Typical volume
    make_sector(4, 1, 2, 512, 200, 8'hF8);
    run("R8", 1'b0, 1'b0);
    chk("R5", "typical root_start", longint'(root_start), 401);
    chk("R6", "typical root_span", longint'(root_span), 32);
    chk("R7", "typical data_start", longint'(data_start), 433);

    // R11 strobes after done are ignored
    sec[13] = 8'h08; sec[511] = 8'h00;
    send_byte(13, 1'b0); send_byte(16, 1'b0); send_byte(511, 1'b0);
    @(negedge clk); byte_valid = 1'b0;
    @(negedge clk);
    chk("R11", "done held after late bytes", longint'(geo_done), 1);
    chk("R11", "clus_sectors unchanged", longint'(clus_sectors), 4);
    chk("R11", "data_start unchanged", longint'(data_start), 433);

    // R6 span corners
    make_sector(1, 1, 1, 0, 9, 8'hF0);      run("R6", 1'b0, 1'b1);
    make_sector(1, 1, 1, 1, 9, 8'hF0);      run("R6", 1'b0, 1'b1);
    make_sector(128, 65535, 255, 65535, 65535, 8'hF8); run("R5", 1'b0, 1'b1);

    // R8 signature bytes
    make_sector(4, 1, 2, 512, 200, 8'hF8); sec[0] = 8'hE9; run("R8", 1'b0, 1'b0);
    make_sector(4, 1, 2, 512, 200, 8'hF8); sec[2] = 8'h00; run("R8", 1'b0, 1'b0);
    // R9 sector size
    make_sector(4, 1, 2, 512, 200, 8'hF8); put16(11, 1024); run("R9", 1'b0, 1'b0);
    make_sector(4, 1, 2, 512, 200, 8'hF8); put16(11, 513); run("R9", 1'b0, 1'b0);
    // R10 cluster size and FAT count
    make_sector(0, 1, 2, 512, 200, 8'hF8); run("R10", 1'b0, 1'b0);
    make_sector(6, 1, 2, 512, 200, 8'hF8); run("R10", 1'b0, 1'b0);
    make_sector(4, 1, 0, 512, 200, 8'hF8); run("R10", 1'b0, 1'b0);

    // R12 reverse order
    make_sector(16, 6, 2, 1024, 250, 8'hF8); run("R12", 1'b1, 1'b0);

    // Random volumes
    for (int n = 0; n < 40; n++) begin
      int spc;
      spc = ($urandom % 5 == 0) ? int'($urandom % 256) : (1 << ($urandom % 8));
      make_sector(spc, int'($urandom % 65536), int'($urandom % 4),
                  int'($urandom % 65536), int'($urandom % 65536), int'($urandom % 256));
      if ($urandom % 8 == 0) sec[0] = 8'(sec[0] ^ 8'h01);
      if ($urandom % 8 == 0) put16(11, 256);
      run("R10", (n % 5) == 4, 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule